// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a multiplexed-address DRAM alive. Out of reset it holds every strobe inactive through a long settling pause. It then runs a fixed burst of refresh cycles on its own and raises `init_done`. From then on an interval timer owes the memory one refresh per row period. For each refresh owed, the block asks the access arbiter for the bus with `ref_req`. When `ref_gnt` comes back, it drives the row strobe, both column strobes and write enable itself.

A parameter picks how rows are named. In the default mode the memory's own row counter is used: both column strobes drop before the row strobe, and the address bus is left alone. In the row-only mode an internal counter puts the row on `row_addr`, drives it with `addr_oe`, and steps it after every cycle. A second parameter sizes the part: 1024 rows retained for 16 ms, or 4096 rows for 64 ms. Refreshes the arbiter has postponed are counted, up to eight, and one grant pays them all back in a single back-to-back burst. The arbiter gives a refresh priority over a new access but waits for a running access to finish. `ref_busy` tells it when the bus is back.

Top module: `dram_refresh_seq`

## Requirements
- R1: During and after reset `ras_n`, `lcas_n`, `ucas_n` and `we_n` are high and `init_done`, `ref_req` and `ref_busy` are low. No strobe moves for `PWRUP_CYC` clock cycles after reset; the default is ceil(200 us / `CLK_NS`).
- R2: After the pause, exactly `INIT_CYCLES` (8) refresh cycles run without any grant. `init_done` then rises and never falls again until reset.
- R3: With `ROW_ONLY`=0, both column strobes are low for at least ceil(5 ns / `CLK_NS`) cycles before `ras_n` falls, and they stay low for as long as `ras_n` is low. `addr_oe` stays 0.
- R4: `we_n` is high at every row strobe fall and throughout every refresh cycle.
- R5: `ras_n` stays low for at least ceil(60 ns / `CLK_NS`) cycles per refresh. Before every fall it has been high for at least ceil(40 ns / `CLK_NS`) cycles.
- R6: After initialization, one refresh is owed every `INTERVAL_CYC` cycles, so with the grant held high the row strobe falls exactly `INTERVAL_CYC` cycles apart. The default is (retention / rows) / `CLK_NS`, with 64 ms for 4096 rows and 16 ms for 1024 rows.
- R7: `ref_req` is high only while the block is idle after initialization and owes at least one refresh. No strobe moves until `ref_gnt` is high while `ref_req` is high. `ref_busy` is high from the start of the sequence to the end of its last precharge.
- R8: Owed refreshes are counted up to `MAX_OWED` (8), and further ticks are dropped. One grant issues every owed refresh back to back.
- R9: With `ROW_ONLY`=1 the column strobes stay high. `addr_oe` is 1 from one cycle before the row strobe falls until it rises. `row_addr` holds while `ras_n` is low, starts at 0 after reset, steps by one after each cycle, and wraps after `ROWS`-1 on a log2(`ROWS`)-bit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_gnt | input | 1 | Bus grant from the access arbiter |
| ref_req | output | 1 | Request for the bus to refresh |
| ref_busy | output | 1 | Sequencer owns the memory strobes |
| init_done | output | 1 | Power-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr_oe | output | 1 | Drive `row_addr` onto the address bus |
| row_addr | output | log2(ROWS) | Row to refresh in row-only mode |

## Verification
The column-first variant is run three ways. First it gets a grant that is always present, which shows the strobe ordering and that the period is exact. Next the grant is withheld for eleven intervals, which shows that the request stays up while nothing moves. Then the grant is given mid-interval, which shows that exactly eight owed refreshes come out in one burst rather than one per tick. A row-only variant with sixteen rows is run through more than one full wrap of its counter, which separates correct sequencing from a counter that stalls or skips. The power-up burst and `init_done` are checked in both variants.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int CLK_NS       = 8,
  parameter int ROWS         = 4096,
  parameter int ROW_ONLY     = 0,
  parameter int INIT_CYCLES  = 8,
  parameter int MAX_OWED     = 8,
  parameter int PWRUP_CYC    = (200000 + CLK_NS - 1) / CLK_NS,
  parameter int INTERVAL_CYC = ((ROWS >= 4096 ? 64000000 : 16000000) / ROWS) / CLK_NS,
  localparam int AW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_gnt,
  output logic          ref_req,
  output logic          ref_busy,
  output logic          init_done,
  output logic          ras_n,
  output logic          lcas_n,
  output logic          ucas_n,
  output logic          we_n,
  output logic          addr_oe,
  output logic [AW-1:0] row_addr
);

  localparam int T_LEAD = (5 + CLK_NS - 1) / CLK_NS;
  localparam int T_RAS  = (60 + CLK_NS - 1) / CLK_NS;
  localparam int T_RP   = (40 + CLK_NS - 1) / CLK_NS;
  localparam int MAXC   = (PWRUP_CYC > T_RAS) ? PWRUP_CYC : T_RAS;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int TW     = $clog2(INTERVAL_CYC + 1);
  localparam int OW     = $clog2(MAX_OWED + 1);

  typedef enum logic [2:0] {S_PAUSE, S_IDLE, S_LEAD, S_RAS, S_PRE} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tmr;
  logic [OW-1:0]  owed, owed_nx;
  logic [AW-1:0]  row;
  logic           done;

  wire pause_end = (st == S_PAUSE) && (cnt == CW'(PWRUP_CYC - 1));
  wire lead_end  = (st == S_LEAD)  && (cnt == CW'(T_LEAD - 1));
  wire ras_end   = (st == S_RAS)   && (cnt == CW'(T_RAS - 1));
  wire pre_end   = (st == S_PRE)   && (cnt == CW'(T_RP - 1));
  wire tick      = done && (tmr == TW'(INTERVAL_CYC - 1));

  always_comb begin
    owed_nx = owed;
    if (pause_end) owed_nx = OW'(INIT_CYCLES);
    else begin
      if (ras_end) owed_nx = owed_nx - OW'(1);
      if (tick && owed_nx != OW'(MAX_OWED)) owed_nx = owed_nx + OW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_PAUSE;
      cnt  <= '0;
      tmr  <= '0;
      owed <= '0;
      row  <= '0;
      done <= 1'b0;
    end else begin
      owed <= owed_nx;
      if (done) tmr <= tick ? '0 : tmr + TW'(1);
      case (st)
        S_PAUSE: begin
          cnt <= pause_end ? '0 : cnt + CW'(1);
          if (pause_end) st <= S_LEAD;
        end
        S_IDLE: if (owed != '0 && ref_gnt) begin
          st  <= S_LEAD;
          cnt <= '0;
        end
        S_LEAD: begin
          cnt <= lead_end ? '0 : cnt + CW'(1);
          if (lead_end) st <= S_RAS;
        end
        S_RAS: begin
          cnt <= ras_end ? '0 : cnt + CW'(1);
          if (ras_end) begin
            st <= S_PRE;
            if (ROW_ONLY != 0) row <= row + AW'(1);
          end
        end
        S_PRE: begin
          cnt <= pre_end ? '0 : cnt + CW'(1);
          if (pre_end) begin
            if (owed != '0) st <= S_LEAD;
            else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire cas_low = (ROW_ONLY == 0) && (st == S_LEAD || st == S_RAS);

  assign ras_n     = (st != S_RAS);
  assign lcas_n    = !cas_low;
  assign ucas_n    = !cas_low;
  assign we_n      = 1'b1;
  assign addr_oe   = (ROW_ONLY != 0) && (st == S_LEAD || st == S_RAS);
  assign row_addr  = (ROW_ONLY != 0) ? row : '0;
  assign ref_req   = done && (st == S_IDLE) && (owed != '0);
  assign ref_busy  = (st == S_LEAD) || (st == S_RAS) || (st == S_PRE);
  assign init_done = done;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int CLK_NS   = 8,
  parameter int ROW_ONLY = 0,
  parameter int AW       = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_req,
  input logic          init_done,
  input logic          ras_n,
  input logic          lcas_n,
  input logic          ucas_n,
  input logic          we_n,
  input logic [AW-1:0] row_addr
);

  localparam int T_RAS = (60 + CLK_NS - 1) / CLK_NS;
  localparam int T_RP  = (40 + CLK_NS - 1) / CLK_NS;

  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n ? '0 : (lo_cnt == 8'hff ? lo_cnt : lo_cnt + 8'd1);
      hi_cnt <= !ras_n ? '0 : (hi_cnt == 8'hff ? hi_cnt : hi_cnt + 8'd1);
    end
  end

  // R3
  cbr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ROW_ONLY == 0 && $fell(ras_n)) |-> (!lcas_n && !ucas_n && !$past(lcas_n) && !$past(ucas_n)));

  // R3
  cbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ROW_ONLY == 0 && !ras_n) |-> (!lcas_n && !ucas_n));

  // R4
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !lcas_n) |-> we_n);

  // R5
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_cnt >= 8'(T_RAS)));

  // R5
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));

  // R7
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (ras_n && lcas_n && ucas_n));

  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr));

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .CLK_NS(CLK_NS), .ROW_ONLY(ROW_ONLY), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .init_done(init_done),
  .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n),
  .row_addr(row_addr)
);

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int CLK_NS  = 8;
  localparam int A_PWR   = 60;
  localparam int A_INT   = 300;
  localparam int B_PWR   = 40;
  localparam int B_INT   = 40;
  localparam int B_ROWS  = 16;
  localparam int EXP_LEAD = (5 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_RAS  = (60 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_RP   = (40 + CLK_NS - 1) / CLK_NS;
  localparam int B_ITEMS  = 24;

  logic clk = 1'b0, rst_n = 1'b0, gA = 1'b1, gB = 1'b1;
  always #4 clk = ~clk;

  logic       a_req, a_busy, a_done, a_ras, a_lcas, a_ucas, a_we, a_oe;
  logic [11:0] a_row;
  logic       b_req, b_busy, b_done, b_ras, b_lcas, b_ucas, b_we, b_oe;
  logic [3:0] b_row;

  dram_refresh_seq #(.CLK_NS(CLK_NS), .ROWS(4096), .ROW_ONLY(0),
    .PWRUP_CYC(A_PWR), .INTERVAL_CYC(A_INT)) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gA), .ref_req(a_req), .ref_busy(a_busy),
    .init_done(a_done), .ras_n(a_ras), .lcas_n(a_lcas), .ucas_n(a_ucas),
    .we_n(a_we), .addr_oe(a_oe), .row_addr(a_row));

  dram_refresh_seq #(.CLK_NS(CLK_NS), .ROWS(B_ROWS), .ROW_ONLY(1),
    .PWRUP_CYC(B_PWR), .INTERVAL_CYC(B_INT)) u_dram_refresh_seq_ro (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gB), .ref_req(b_req), .ref_busy(b_busy),
    .init_done(b_done), .ras_n(b_ras), .lcas_n(b_lcas), .ucas_n(b_ucas),
    .we_n(b_we), .addr_oe(b_oe), .row_addr(b_row));

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // ---------------- monitor A (column-first variant)
  int  a_falls = 0, a_lo = 0, a_hi = 0, a_lead = 0, a_last_fall = 0, a_ep = 0, a_last_ep = 0;
  bit  a_prev_ras = 1'b1, a_prev_done = 1'b0, a_prev_busy = 1'b0;
  bit  a_cas_slip = 1'b0, intv_phase = 1'b0, intv_have = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (a_prev_ras && !a_ras) begin
      a_falls++;
      if (a_falls == 1) check(cyc >= A_PWR, "R1", "first strobe cycle", cyc, A_PWR);
      else check(a_hi >= EXP_RP, "R5", "precharge width", a_hi, EXP_RP);
      check(!a_lcas && !a_ucas, "R3", "column strobes low at row fall", {a_lcas, a_ucas}, 0);
      check(a_lead >= EXP_LEAD, "R3", "column lead cycles", a_lead, EXP_LEAD);
      check(a_we, "R4", "write enable at row fall", a_we, 1);
      check(!a_oe, "R3", "address drive in column-first mode", a_oe, 0);
      if (intv_phase) begin
        if (intv_have) check(cyc - a_last_fall == A_INT, "R6", "refresh spacing", cyc - a_last_fall, A_INT);
        intv_have = 1'b1;
      end
      if (a_busy) a_ep++;
      a_last_fall = cyc;
      a_lo = 0; a_lead = 0; a_cas_slip = 1'b0;
    end
    if (!a_prev_ras && a_ras) begin
      check(a_lo >= EXP_RAS, "R5", "row strobe low width", a_lo, EXP_RAS);
      check(!a_cas_slip, "R3", "column strobes held during row low", a_cas_slip, 0);
      a_hi = 0;
    end
    if (!a_ras) begin
      a_lo++;
      if (a_lcas || a_ucas || !a_we) a_cas_slip = 1'b1;
    end else begin
      a_hi++;
      if (!a_lcas) a_lead++; else a_lead = 0;
    end
    if (!a_prev_done && a_done)
      check(a_falls == 8, "R2", "refresh cycles before init_done", a_falls, 8);
    if (a_prev_busy && !a_busy) begin
      a_last_ep = a_ep; a_ep = 0;
    end
    a_prev_ras  = a_ras;
    a_prev_done = a_done;
    a_prev_busy = a_busy;
  end

  // ---------------- scoreboard for B (row-only variant)
  typedef struct { int addr; } exp_t;
  exp_t b_q[$];
  bit   b_prev_ras = 1'b1, b_slip = 1'b0;
  int   b_seen = 0;

  task automatic push_rows(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.addr = i % B_ROWS;
      b_q.push_back(e);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (b_prev_ras && !b_ras && b_q.size() > 0) begin
      exp_t e;
      e = b_q.pop_front();
      b_seen++;
      check(int'(b_row) == e.addr, "R9", "refreshed row", int'(b_row), e.addr);
      check(b_oe && b_lcas && b_ucas, "R9", "address driven, columns idle", {b_oe, b_lcas, b_ucas}, 7);
      check(b_we, "R4", "write enable in row-only cycle", b_we, 1);
    end
    if (!b_ras && (!b_oe || !b_lcas)) b_slip = 1'b1;
    b_prev_ras = b_ras;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int falls_before, target;
    push_rows(B_ITEMS);
    repeat (3) @(negedge clk);
    check(a_ras && a_lcas && a_ucas && a_we, "R1", "strobes idle in reset",
          {a_ras, a_lcas, a_ucas, a_we}, 15);
    check(!a_done && !a_req && !a_busy, "R1", "status low in reset",
          {a_done, a_req, a_busy}, 0);
    rst_n = 1'b1;
    repeat (A_PWR - 2) @(negedge clk);
    check(a_falls == 0 && a_ras && a_lcas, "R1", "quiet during pause", a_falls, 0);
    wait (a_done);
    @(negedge clk);
    intv_phase = 1'b1;
    while (a_falls < 12) @(negedge clk);
    intv_phase = 1'b0;
    gA = 1'b0;
    falls_before = a_falls;
    target = a_last_fall + 11 * A_INT + A_INT / 2;
    while (cyc < target) @(negedge clk);
    check(a_falls == falls_before, "R7", "strobes without grant", a_falls - falls_before, 0);
    check(a_req && !a_busy, "R7", "request pending while refused", {a_req, a_busy}, 2);
    gA = 1'b1;
    wait (a_busy);
    wait (!a_busy);
    @(negedge clk);
    @(negedge clk);
    check(a_last_ep == 8, "R8", "burst length after postponement", a_last_ep, 8);
    check(a_done, "R2", "init_done stays high", a_done, 1);
    check(b_seen == B_ITEMS && b_q.size() == 0, "R9", "row sequence consumed", b_seen, B_ITEMS);
    check(!b_slip, "R9", "row-only strobe/drive relation", b_slip, 0);
    check(b_done, "R2", "row-only init_done", b_done, 1);
    finish_run();
  end
endmodule